// File: doc/BRIEF.md
# Sampled Phase-Frequency Comparator with Lock Indication

This block compares two slow square-wave signals, a divided oscillator signal and a reference comparison signal, and emits correction pulses for a synthesiser loop. Both inputs are sampled by a fast system clock. After a short synchroniser, only their rising edges are used. When the divided-oscillator edge arrives first, the UP output goes high. When the reference edge arrives first, the DN output goes high. Either pulse ends on the matching edge of the other input. The pulse width in clock cycles therefore equals the edge separation, so the duty cycle tracks the phase difference linearly across one full cycle.

The core is a tri-state detector built from two state flops. A rising edge sets its own flop. When both flops would be set, both are cleared in the same cycle. If the leading input produces another rising edge before the lagging input has answered, the phase error has passed one full cycle. That edge is absorbed, so the detector gains or slips one cycle rather than saturating, and the output pattern repeats with a one-cycle period. A lock flag is high whenever no correction pulse is active.

Top module: `pfd_lock_top`

## Requirements
- R1: While the active-low reset is held, UP and DN are 0 and LOCK is 1 at every clock edge.
- R2: A rising edge on the divided-oscillator input that precedes the next reference rising edge by G clock cycles (G ≥ 1) produces one UP pulse exactly G cycles wide. DN stays low throughout.
- R3: A rising edge on the reference input that precedes the next divided-oscillator rising edge by G clock cycles (G ≥ 1) produces one DN pulse exactly G cycles wide. UP stays low throughout.
- R4: Rising edges on both inputs in the same sample cycle produce no pulse on either output, and LOCK stays 1.
- R5: UP and DN are never high in the same clock cycle. The sampled model gives a zero-width overlap when the active pulse ends.
- R6: A further rising edge on the leading input while its pulse is pending has no effect. The pulse continues and ends on the next rising edge of the other input.
- R7: LOCK is 1 exactly when both UP and DN are 0.
- R8: Falling edges on either input neither start nor end a pulse.
- R9: Asserting reset during a pulse drives UP and DN to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference comparison signal (asynchronous) |
| div_i | input | 1 | Divided oscillator signal (asynchronous) |
| up_o | output | 1 | Correction pulse: divided oscillator leads |
| dn_o | output | 1 | Correction pulse: divided oscillator lags |
| lock_o | output | 1 | High while no correction pulse is active |

## Verification
The bench builds the block with the default two-stage synchroniser. Each output then follows its input edge by three clock edges, so edge separations from one cycle up to several dozen cycles fit in short scripted windows. The one-cycle gap, coincident edges, an edge absorbed during a pending pulse, and a reset that cuts a pulse short all become reachable this way. The same latency on both inputs means every expected pulse width is simply the driven edge separation.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } pfd_state_t;

  // Tri-state detector step: each rising edge sets its own side and
  // a pending side stays set until both are set, then both clear.
  function automatic pfd_state_t pfd_step(pfd_state_t cur,
                                          logic div_rise,
                                          logic ref_rise);
    pfd_state_t nxt;
    logic up_set;
    logic dn_set;
    up_set = cur.up | div_rise;
    dn_set = cur.dn | ref_rise;
    if (up_set && dn_set) begin
      nxt.up = 1'b0;
      nxt.dn = 1'b0;
    end else begin
      nxt.up = up_set;
      nxt.dn = dn_set;
    end
    return nxt;
  endfunction

  function automatic logic pfd_idle(pfd_state_t s);
    return ~(s.up | s.dn);
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  localparam int W = STAGES + 1;

  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[W-2:0], sig_i};
  end

  // sh_q[STAGES-1] is the synchronised level; sh_q[STAGES] is its last value
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic div_rise_i,
  input  logic ref_rise_i,
  output logic up_o,
  output logic dn_o,
  output logic lock_o
);
  pfd_state_t state_q;
  pfd_state_t state_d;
  logic       lock_q;

  always_comb state_d = pfd_step(state_q, div_rise_i, ref_rise_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      lock_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      lock_q  <= pfd_idle(state_d);
    end
  end

  assign up_o   = state_q.up;
  assign dn_o   = state_q.dn;
  assign lock_o = lock_q;
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic div_i,
  output logic up_o,
  output logic dn_o,
  output logic lock_o
);
  localparam int NCH = 2;  // channel 0: divided oscillator, 1: reference

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] rise_vec;
  logic           div_rise;
  logic           ref_rise;

  assign raw_in = {ref_i, div_i};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (raw_in[c]),
      .rise_o (rise_vec[c])
    );
  end

  assign div_rise = rise_vec[0];
  assign ref_rise = rise_vec[1];

  pfd_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_rise_i (div_rise),
    .ref_rise_i (ref_rise),
    .up_o       (up_o),
    .dn_o       (dn_o),
    .lock_o     (lock_o)
  );
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic up,
  input logic dn,
  input logic lock,
  input logic div_rise,
  input logic ref_rise
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!up && !dn && lock));

  // R2
  up_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_rise && !ref_rise && !dn && !up) |=> (up && !dn));

  // R2
  up_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && ref_rise) |=> (!up && !dn));

  // R3
  dn_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !div_rise && !up && !dn) |=> (dn && !up));

  // R3
  dn_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn && div_rise) |=> (!up && !dn));

  // R4
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_rise && ref_rise && !up && !dn) |=> (!up && !dn));

  // R5
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));

  // R6
  absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && div_rise && !ref_rise) |=> up);

  // R7
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock == !(up || dn));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_rise && !ref_rise) |=> ($stable(up) && $stable(dn)));
endmodule

bind pfd_lock_top pfd_lock_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .up       (up_o),
  .dn       (dn_o),
  .lock     (lock_o),
  .div_rise (div_rise),
  .ref_rise (ref_rise)
);

// File: tb/pfd_lock_top_tb.sv
module pfd_lock_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int SETTLE = SYNC + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_i = 1'b0;
  logic div_i = 1'b0;
  logic up_o, dn_o, lock_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // scoreboard queues: side (1 = UP), width, requirement tag
  bit    q_up[$];
  int    q_w[$];
  string q_req[$];

  pfd_lock_top #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .div_i(div_i),
    .up_o(up_o), .dn_o(dn_o), .lock_o(lock_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pulse(bit is_up, int width, string req);
    q_up.push_back(is_up);
    q_w.push_back(width);
    q_req.push_back(req);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_quiet(int n, string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (up_o || dn_o || !lock_o) seen++;
    end
    check(seen == 0, req, "activity samples in quiet window", seen, 0);
  endtask

  // lead_div: divided input rises first; gap cycles later the other rises
  task automatic edge_pair(bit lead_div, int gap, string req);
    if (gap > 0) expect_pulse(lead_div, gap, req);
    if (lead_div) div_i = 1'b1; else ref_i = 1'b1;
    if (gap > 0) tick(gap);
    if (lead_div) ref_i = 1'b1; else div_i = 1'b1;
    tick(4);
    div_i = 1'b0;
    ref_i = 1'b0;
    tick(SETTLE);
  endtask

  // monitor: measure pulses and compare against scoreboard
  int up_run = 0;
  int dn_run = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      up_run = 0;
      dn_run = 0;
    end else begin
      // R7 lock flag mirrors absence of pulses; R5 exclusivity
      if (lock_o != !(up_o || dn_o))
        check(1'b0, "R7", "lock vs outputs", lock_o, !(up_o || dn_o));
      if (up_o && dn_o)
        check(1'b0, "R5", "both outputs high", 1, 0);
      if (up_o) up_run++;
      else if (up_run > 0) begin
        if (q_w.size() == 0) check(1'b0, "R4", "unexpected UP pulse", up_run, 0);
        else begin
          automatic bit    e_up  = q_up.pop_front();
          automatic int    e_w   = q_w.pop_front();
          automatic string e_req = q_req.pop_front();
          check(e_up == 1'b1, e_req, "pulse side UP", 1, e_up);
          check(up_run == e_w, e_req, "UP pulse width", up_run, e_w);
        end
        up_run = 0;
      end
      if (dn_o) dn_run++;
      else if (dn_run > 0) begin
        if (q_w.size() == 0) check(1'b0, "R4", "unexpected DN pulse", dn_run, 0);
        else begin
          automatic bit    e_up  = q_up.pop_front();
          automatic int    e_w   = q_w.pop_front();
          automatic string e_req = q_req.pop_front();
          check(e_up == 1'b0, e_req, "pulse side DN", 0, e_up);
          check(dn_run == e_w, e_req, "DN pulse width", dn_run, e_w);
        end
        dn_run = 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    check(!up_o && !dn_o && lock_o, "R1", "outputs during reset",
          {up_o, dn_o, lock_o}, 3'b001);
    rst_n = 1'b1;
    tick(SETTLE);

    edge_pair(1'b1, 5, "R2");   // divided leads
    edge_pair(1'b0, 3, "R3");   // reference leads
    edge_pair(1'b1, 1, "R2");   // minimum gap
    edge_pair(1'b0, 1, "R3");

    // R4 coincident edges
    div_i = 1'b1;
    ref_i = 1'b1;
    expect_quiet(8, "R4");
    div_i = 1'b0;
    ref_i = 1'b0;
    tick(SETTLE);

    // R6 second leading edge absorbed; divided fall also ignored (R8)
    expect_pulse(1'b1, 7, "R6");
    div_i = 1'b1; tick(2);
    div_i = 1'b0; tick(2);
    div_i = 1'b1; tick(3);
    ref_i = 1'b1; tick(4);
    div_i = 1'b0; ref_i = 1'b0;
    tick(SETTLE);

    // R8 reference falls while its pulse is pending
    expect_pulse(1'b0, 6, "R8");
    ref_i = 1'b1; tick(2);
    ref_i = 1'b0; tick(4);
    div_i = 1'b1; tick(4);
    div_i = 1'b0;
    tick(SETTLE);

    // R8 falling edges alone do nothing
    expect_quiet(6, "R8");

    edge_pair(1'b0, 40, "R3");  // wide pulse
    edge_pair(1'b1, 23, "R2");

    // R9 reset mid-pulse
    div_i = 1'b1;
    tick(SYNC + 3);
    check(up_o, "R9", "UP active before reset", up_o, 1);
    rst_n = 1'b0;
    #1;
    check(!up_o && !dn_o, "R9", "outputs right after reset",
          {up_o, dn_o}, 0);
    tick(2);
    check(!up_o && !dn_o && lock_o, "R1", "outputs held in reset",
          {up_o, dn_o, lock_o}, 3'b001);
    div_i = 1'b0;
    tick(SETTLE);
    rst_n = 1'b1;
    expect_quiet(SETTLE, "R9");

    check(q_w.size() == 0, "R2", "missing pulses", q_w.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule